// File: doc/BRIEF.md
# Predicated Vector Arithmetic Shifter with Wide Shift Lanes

This block shifts every element of a fixed-length data vector right arithmetically. The bits that enter from the top are copies of each element's sign bit. Elements are 8, 16 or 32 bits wide, chosen by a two-bit size code.

The shift amounts come from a second vector, read as 64-bit unsigned lanes. Every narrow element uses the lane whose bit range contains it, so several elements share one amount. All 64 bits of an amount count: an amount is never folded modulo the element width. An amount at or above the element width gives the element width as the shift, which leaves pure sign fill.

A byte-granular predicate picks which elements are updated. An element that is not selected passes its input value through, because the data vector is both the source and the destination. One input valid per operation gives a registered result and a valid flag one clock later. The vector length is a parameter.

Top module: `vec_wide_asr`

## Requirements
- R1: Size code 0 selects 8-bit elements, 1 selects 16-bit elements and 2 selects 32-bit elements. Element 0 sits at bit 0 of the vector, and each later element sits directly above the one before it.
- R2: Element e of width W takes its amount from 64-bit lane floor(e*W/64) of `shamt`. Lane k occupies bits [64k+63:64k].
- R3: The amount is an unsigned 64-bit number and every bit of it counts. Any amount of W or more behaves as a shift by W and gives an element that is all copies of its sign bit. For example, an amount of 2^32 does not act as a shift of 0.
- R4: A shift by s < W gives the element's bits moved down by s, with the top s bits filled with the element's bit W-1.
- R5: Element e is active when predicate bit e*W/8 is 1. The other predicate bits inside that element have no effect.
- R6: An inactive element comes out equal to the matching element of `src_a`.
- R7: Size code 3 sets `bad_size` to 1 and makes `result` equal to `src_a`. Codes 0 to 2 set `bad_size` to 0.
- R8: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high. `result` and `bad_size` change only after a cycle with `in_valid` high.
- R9: Synchronous reset clears `out_valid`, `result` and `bad_size` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request; inputs are sampled in this cycle |
| size_sel | input | 2 | Element size code (0: 8, 1: 16, 2: 32, 3: illegal) |
| src_a | input | VLEN | Data vector, which is also the merge source |
| shamt | input | VLEN | Shift amounts as 64-bit unsigned lanes |
| pred | input | VLEN/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | VLEN | Shifted and merged vector |
| bad_size | output | 1 | The last sampled size code was illegal |

## Verification
A vector of negative bytes, with a different amount in each 64-bit lane, shows whether each element reads its own overlapping lane or a lane chosen by element index. Amounts of W-1, W and 2^32 separate correct clamping from modulo reduction and from off-by-one clamping. One set of predicates has bits set only at positions that are not element starts, and a second has bits only at element starts; together they show that only the lowest predicate bit of each element is read. Random data, amounts and predicates at every legal size, together with the illegal code and idle cycles, are compared against a bit-level reference model written separately inside the bench.

// File: rtl/vwasr_pkg.sv
package vwasr_pkg;
  localparam int LANE_W = 64;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } esize_e;

  localparam int N_SIZES = 3;
endpackage

// File: rtl/vwasr_elem.sv
module vwasr_elem #(
  parameter int EW = 8
) (
  input  logic [EW-1:0] din,
  input  logic [63:0]   amt,
  input  logic          act,
  output logic [EW-1:0] dout
);
  localparam int SW = $clog2(EW) + 1;

  logic          over;
  logic [SW-1:0] eff;
  logic [EW-1:0] shifted;

  always_comb begin
    over    = (amt >= 64'(EW));
    eff     = over ? SW'(EW) : amt[SW-1:0];
    shifted = EW'($signed(din) >>> eff);
    dout    = act ? shifted : din;
  end
endmodule

// File: rtl/vwasr_group.sv
module vwasr_group #(
  parameter int VLEN = 256,
  parameter int EW   = 8
) (
  input  logic [VLEN-1:0]    a,
  input  logic [VLEN-1:0]    b,
  input  logic [VLEN/EW-1:0] act,
  output logic [VLEN-1:0]    y
);
  import vwasr_pkg::*;
  localparam int NE = VLEN / EW;

  for (genvar e = 0; e < NE; e++) begin : g_el
    localparam int LANE = (e * EW) / LANE_W;
    vwasr_elem #(.EW(EW)) el_i (
      .din (a[e*EW +: EW]),
      .amt (b[LANE*LANE_W +: LANE_W]),
      .act (act[e]),
      .dout(y[e*EW +: EW])
    );
  end
endmodule

// File: rtl/vec_wide_asr.sv
module vec_wide_asr #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        size_sel,
  input  logic [VLEN-1:0]   src_a,
  input  logic [VLEN-1:0]   shamt,
  input  logic [VLEN/8-1:0] pred,
  output logic              out_valid,
  output logic [VLEN-1:0]   result,
  output logic              bad_size
);
  import vwasr_pkg::*;

  logic [VLEN-1:0] grp_y [N_SIZES];
  logic [VLEN-1:0] nxt_y;
  logic            nxt_bad;

  for (genvar g = 0; g < N_SIZES; g++) begin : g_sz
    localparam int EW = 8 << g;
    localparam int NE = VLEN / EW;
    logic [NE-1:0] act;
    for (genvar e = 0; e < NE; e++) begin : g_act
      assign act[e] = pred[e * (EW / 8)];
    end
    vwasr_group #(.VLEN(VLEN), .EW(EW)) grp_i (
      .a  (src_a),
      .b  (shamt),
      .act(act),
      .y  (grp_y[g])
    );
  end

  always_comb begin
    nxt_bad = 1'b0;
    case (esize_e'(size_sel))
      SZ_BYTE: nxt_y = grp_y[0];
      SZ_HALF: nxt_y = grp_y[1];
      SZ_WORD: nxt_y = grp_y[2];
      default: begin
        nxt_y   = src_a;
        nxt_bad = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      bad_size  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= nxt_y;
        bad_size <= nxt_bad;
      end
    end
  end
endmodule

// File: rtl/vwasr_chk.sv
module vwasr_chk #(
  parameter int VLEN = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        size_sel,
  input logic [VLEN-1:0]   src_a,
  input logic [VLEN-1:0]   shamt,
  input logic [VLEN/8-1:0] pred,
  input logic              out_valid,
  input logic [VLEN-1:0]   result,
  input logic              bad_size
);
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(bad_size)));
  p_bad_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'd3) |=> (bad_size && result == $past(src_a)));
  p_good_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel != 2'd3) |=> !bad_size);
  p_clamp_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'd2 && pred[0] && shamt[63:0] >= 64'd32)
      |=> (result[31:0] == {32{$past(src_a[31])}}));

  for (genvar b = 0; b < VLEN / 8; b++) begin : g_byte
    p_inactive_r6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && size_sel == 2'd0 && !pred[b])
        |=> (result[b*8 +: 8] == $past(src_a[b*8 +: 8])));
  end
endmodule

bind vec_wide_asr vwasr_chk #(.VLEN(VLEN)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .size_sel(size_sel),
  .src_a(src_a), .shamt(shamt), .pred(pred), .out_valid(out_valid),
  .result(result), .bad_size(bad_size)
);

// File: tb/vec_wide_asr_tb_top.sv
module vec_wide_asr_tb_top;
  localparam int VL = 256;
  localparam int PW = VL / 8;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [1:0]    size_sel;
  logic [VL-1:0] src_a, shamt;
  logic [PW-1:0] pred;
  logic          out_valid, bad_size;
  logic [VL-1:0] result;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vec_wide_asr #(.VLEN(VL)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_sel(size_sel),
    .src_a(src_a), .shamt(shamt), .pred(pred), .out_valid(out_valid),
    .result(result), .bad_size(bad_size)
  );

  function automatic logic [VL-1:0] ref_model(input logic [1:0] sz,
      input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [PW-1:0] p);
    logic [VL-1:0] r;
    r = a;
    if (sz != 2'd3) begin
      int ew;
      ew = 8 << sz;
      for (int e = 0; e < VL / ew; e++) begin
        logic [63:0] amt;
        int sh;
        amt = b[((e * ew) / 64) * 64 +: 64];
        sh  = (amt > 64'(ew)) ? ew : int'(amt);
        if (p[(e * ew) / 8]) begin
          for (int i = 0; i < ew; i++) begin
            r[e*ew + i] = (i + sh < ew) ? a[e*ew + i + sh] : a[e*ew + ew - 1];
          end
        end
      end
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] v;
    for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic chk(input string rq, input logic [VL-1:0] got,
      input logic [VL-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", rq, got, exp);
    end
  endtask

  task automatic apply(input string rq, input logic [1:0] sz,
      input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [PW-1:0] p);
    @(negedge clk);
    size_sel = sz; src_a = a; shamt = b; pred = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({rq, " valid"}, VL'(out_valid), VL'(1));
    chk({rq, " bad_size"}, VL'(bad_size), VL'(sz == 2'd3));
    chk(rq, result, ref_model(sz, a, b, p));
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; size_sel = '0;
    src_a = '0; shamt = '0; pred = '0;
    repeat (3) @(negedge clk);
    chk("R9 valid", VL'(out_valid), '0);
    chk("R9 result", result, '0);
    chk("R9 bad", VL'(bad_size), '0);
    rst = 1'b0;
  endtask

  task automatic t_lane_map();
    logic [VL-1:0] b;
    for (int k = 0; k < VL / 64; k++) b[k*64 +: 64] = 64'(k + 1);
    apply("R1 R2 R4 bytes", 2'd0, {(VL/8){8'h96}}, b, '1);
    apply("R2 halves", 2'd1, {(VL/16){16'h8421}}, b, '1);
    apply("R2 words", 2'd2, {(VL/32){32'hC001_7FF3}}, b, '1);
  endtask

  task automatic t_clamp();
    for (int s = 0; s < 3; s++) begin
      int ew;
      ew = 8 << s;
      apply("R3 W-1", 2'(s), rnd_vec(), {(VL/64){64'(ew - 1)}}, '1);
      apply("R3 W", 2'(s), rnd_vec(), {(VL/64){64'(ew)}}, '1);
      apply("R3 2^32", 2'(s), {(VL/8){8'hA5}}, {(VL/64){64'h1_0000_0000}}, '1);
      apply("R3 max", 2'(s), {(VL/8){8'h5A}}, {(VL/64){64'hFFFF_FFFF_FFFF_FFFF}}, '1);
    end
  endtask

  task automatic t_pred();
    logic [PW-1:0] off_start, on_start;
    for (int i = 0; i < PW; i++) begin
      off_start[i] = (i % 4) != 0;
      on_start[i]  = (i % 4) == 0;
    end
    apply("R5 R6 non-start bits", 2'd2, rnd_vec(), {(VL/64){64'd3}}, off_start);
    apply("R5 start bits", 2'd2, rnd_vec(), {(VL/64){64'd3}}, on_start);
    apply("R6 none active", 2'd0, rnd_vec(), {(VL/64){64'd2}}, '0);
    apply("R5 half alternating", 2'd1, rnd_vec(), rnd_vec(), {(PW/2){2'b01}});
  endtask

  task automatic t_bad();
    apply("R7 illegal", 2'd3, rnd_vec(), {(VL/64){64'd1}}, '1);
    apply("R7 legal after", 2'd0, rnd_vec(), {(VL/64){64'd1}}, '1);
  endtask

  task automatic t_hold();
    logic [VL-1:0] kept;
    apply("R8 setup", 2'd3, rnd_vec(), '0, '1);
    kept = result;
    size_sel = 2'd0; src_a = rnd_vec(); shamt = '0; pred = '1;
    repeat (2) @(negedge clk);
    chk("R8 idle valid", VL'(out_valid), '0);
    chk("R8 idle result", result, kept);
    chk("R8 idle bad", VL'(bad_size), VL'(1));
  endtask

  task automatic t_random();
    for (int n = 0; n < 300; n++) begin
      logic [VL-1:0] b;
      logic [PW-1:0] p;
      b = rnd_vec();
      for (int k = 0; k < VL / 64; k++)
        if ($urandom % 4 != 0) b[k*64 +: 64] = 64'($urandom % 40);
      for (int i = 0; i < PW; i++) p[i] = $urandom % 2 == 1;
      apply("R1 R4 R5 random", 2'($urandom % 4), rnd_vec(), b, p);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_lane_map();
    t_clamp();
    t_pred();
    t_bad();
    t_hold();
    t_random();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule